// File: doc/BRIEF.md
# Serial Receive Error Detector

This block sits next to a serial receiver and judges each finished frame. On the cycle the receiver reports frame completion, it takes the data bits, the parity bit and the sampled stop bits as the receiver captured them. It also takes a flag saying the previous character is still unread and the current line mode. From these it decides whether a framing, parity or overrun condition occurred. Each condition has its own enable.

Results appear one clock later, at the same edge as the registered receive-complete pulse. Every detected condition sets its own sticky status flag. Any detected condition also sets a sticky error interrupt request. Software drops each flag with its own clear strobe. A condition that is detected in the same cycle as its clear keeps the flag set. Sampling, shifting and baud generation happen outside this block.

Top module: `ser_rx_err_det`

## Requirements
- R1: `rx_done_o` is high for exactly one cycle, in the cycle after each cycle in which `frame_done_i` is high, and is low at all other times.
- R2: In asynchronous mode (`mode_i[0]`=1) with `fe_en_i`=1, a frame whose first stop bit (`stop_i[0]`) is 0 sets `fe_o`.
- R3: The second stop bit (`stop_i[1]`) is checked only when `two_stop_i`=1. With `two_stop_i`=0, a low `stop_i[1]` sets no flag.
- R4: When `pe_en_i`=1, the mode is asynchronous and a parity bit is present (`mode_i[1]`=1), `pe_o` is set if the XOR of `data_i` and `par_bit_i` differs from `par_odd_i` (0 selects even, 1 selects odd). With `mode_i[1]`=0 the parity bit is ignored.
- R5: In synchronous mode (`mode_i[0]`=0), the stop and parity inputs set neither `fe_o` nor `pe_o`.
- R6: With `oe_en_i`=1, a frame completing while `buf_unread_i`=1 sets `oe_o`, in any mode.
- R7: `err_irq_o` is set at the same edge that raises `rx_done_o` whenever at least one flag-setting condition holds for that frame. It never rises at any other time.
- R8: Each flag stays set until its own clear strobe (`clr_fe_i`, `clr_pe_i`, `clr_oe_i`, `clr_irq_i`) is sampled high. A condition detected in the same cycle as the clear leaves the flag set.
- R9: A frame with several conditions sets all of the matching flags at the same edge.
- R10: After reset all outputs are 0.
- R11: A condition whose enable input is 0 changes no flag and does not set `err_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_done_i | input | 1 | Frame completion pulse from the receiver |
| data_i | input | DATA_W | Received data bits |
| par_bit_i | input | 1 | Received parity bit |
| stop_i | input | STOP_W | Sampled stop bits, index 0 first |
| buf_unread_i | input | 1 | Previous character not yet read |
| mode_i | input | 2 | Bit 0: asynchronous; bit 1: parity bit present |
| two_stop_i | input | 1 | Check the second stop bit |
| par_odd_i | input | 1 | Odd parity select |
| fe_en_i | input | 1 | Framing check enable |
| pe_en_i | input | 1 | Parity check enable |
| oe_en_i | input | 1 | Overrun check enable |
| clr_fe_i | input | 1 | Clear framing flag |
| clr_pe_i | input | 1 | Clear parity flag |
| clr_oe_i | input | 1 | Clear overrun flag |
| clr_irq_i | input | 1 | Clear error interrupt |
| rx_done_o | output | 1 | Registered receive-complete pulse |
| fe_o | output | 1 | Sticky framing error flag |
| pe_o | output | 1 | Sticky parity error flag |
| oe_o | output | 1 | Sticky overrun error flag |
| err_irq_o | output | 1 | Sticky error interrupt request |

## Verification
Every result has a latency of one register. The flags, the interrupt and `rx_done_o` all change at the first rising edge that samples `frame_done_i` or a clear strobe high. The driver changes inputs on the falling edge. When it launches a frame, it queues the flag state that its model predicts for that frame. The monitor takes one entry from the queue on each falling edge where `rx_done_o` is high, half a cycle after the edge that produced the result, and compares it with the outputs. A done pulse that arrives with the queue empty counts as a failure. Checks after a clear alone are sampled at the next falling edge in the same way.

// File: rtl/ser_rx_err_pkg.sv
package ser_rx_err_pkg;
  localparam int unsigned N_ERR = 3;
  localparam int unsigned IDX_FE = 0;
  localparam int unsigned IDX_PE = 1;
  localparam int unsigned IDX_OE = 2;
  localparam int unsigned MODE_ASYNC_BIT = 0;
  localparam int unsigned MODE_PAR_BIT = 1;
  typedef logic [N_ERR-1:0] err_vec_t;
endpackage

// File: rtl/ser_rx_frame_chk.sv
module ser_rx_frame_chk
  import ser_rx_err_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STOP_W = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic [STOP_W-1:0] stop_i,
  input  logic              buf_unread_i,
  input  logic [1:0]        mode_i,
  input  logic              two_stop_i,
  input  logic              par_odd_i,
  input  logic              fe_en_i,
  input  logic              pe_en_i,
  input  logic              oe_en_i,
  output err_vec_t          hit_o
);
  logic [STOP_W-1:0] stop_chk;
  logic              is_async;
  logic              has_par;
  logic              par_bad;

  // stop bit 0 always checked, the rest only in two-stop configuration
  for (genvar i = 0; i < STOP_W; i++) begin : g_stop
    if (i == 0) begin : g_first
      assign stop_chk[i] = 1'b1;
    end else begin : g_extra
      assign stop_chk[i] = two_stop_i;
    end
  end

  assign is_async = mode_i[MODE_ASYNC_BIT];
  assign has_par  = mode_i[MODE_PAR_BIT];
  assign par_bad  = ((^data_i) ^ par_bit_i) != par_odd_i;

  always_comb begin
    hit_o         = '0;
    hit_o[IDX_FE] = fe_en_i && is_async && |(stop_chk & ~stop_i);
    hit_o[IDX_PE] = pe_en_i && is_async && has_par && par_bad;
    hit_o[IDX_OE] = oe_en_i && buf_unread_i;
  end
endmodule

// File: rtl/ser_rx_sticky_flag.sv
module ser_rx_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ser_rx_err_det.sv
module ser_rx_err_det
  import ser_rx_err_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STOP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic [STOP_W-1:0] stop_i,
  input  logic              buf_unread_i,
  input  logic [1:0]        mode_i,
  input  logic              two_stop_i,
  input  logic              par_odd_i,
  input  logic              fe_en_i,
  input  logic              pe_en_i,
  input  logic              oe_en_i,
  input  logic              clr_fe_i,
  input  logic              clr_pe_i,
  input  logic              clr_oe_i,
  input  logic              clr_irq_i,
  output logic              rx_done_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              oe_o,
  output logic              err_irq_o
);
  err_vec_t hit, set_v, clr_v, flag_q;
  logic     done_q;

  ser_rx_frame_chk #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_chk (
    .data_i, .par_bit_i, .stop_i, .buf_unread_i, .mode_i, .two_stop_i,
    .par_odd_i, .fe_en_i, .pe_en_i, .oe_en_i, .hit_o(hit)
  );

  assign set_v = frame_done_i ? hit : '0;
  always_comb begin
    clr_v         = '0;
    clr_v[IDX_FE] = clr_fe_i;
    clr_v[IDX_PE] = clr_pe_i;
    clr_v[IDX_OE] = clr_oe_i;
  end

  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    ser_rx_sticky_flag u_flag (
      .clk_i, .rst_ni, .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(flag_q[i])
    );
  end

  ser_rx_sticky_flag u_irq (
    .clk_i, .rst_ni, .set_i(|set_v), .clr_i(clr_irq_i), .q_o(err_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= frame_done_i;
  end

  assign rx_done_o = done_q;
  assign fe_o      = flag_q[IDX_FE];
  assign pe_o      = flag_q[IDX_PE];
  assign oe_o      = flag_q[IDX_OE];
endmodule

// File: rtl/ser_rx_err_det_sva.sv
module ser_rx_err_det_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_done_i,
  input logic [1:0] mode_i,
  input logic       buf_unread_i,
  input logic       fe_en_i,
  input logic       oe_en_i,
  input logic       clr_fe_i,
  input logic       clr_pe_i,
  input logic       clr_oe_i,
  input logic       rx_done_o,
  input logic       fe_o,
  input logic       pe_o,
  input logic       oe_o,
  input logic       err_irq_o
);
  a_r1_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> rx_done_o);
  a_r1_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> !rx_done_o);
  a_r7_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> rx_done_o);
  a_r5_sync_no_fe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !mode_i[0] && !fe_o) |=> !fe_o);
  a_r5_sync_no_pe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !mode_i[0] && !pe_o) |=> !pe_o);
  a_r6_r8_overrun_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && oe_en_i && buf_unread_i) |=> (oe_o && err_irq_o));
  a_r8_fe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !clr_fe_i) |=> fe_o);
  a_r8_pe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_o && !clr_pe_i) |=> pe_o);
  a_r8_oe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !clr_oe_i) |=> oe_o);
  a_r11_fe_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !fe_en_i && !fe_o) |=> !fe_o);
  a_r7_flag_rise_has_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fe_o) || $rose(pe_o) || $rose(oe_o)) |-> (err_irq_o && rx_done_o));
endmodule

bind ser_rx_err_det ser_rx_err_det_sva u_sva (
  .clk_i, .rst_ni, .frame_done_i, .mode_i, .buf_unread_i, .fe_en_i, .oe_en_i,
  .clr_fe_i, .clr_pe_i, .clr_oe_i, .rx_done_o, .fe_o, .pe_o, .oe_o, .err_irq_o
);

// File: tb/tb_ser_rx_err_det.sv
module tb_ser_rx_err_det;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned STOP_W = 2;

  typedef struct packed {
    logic fe, pe, oe, irq;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame_done_i = 0, par_bit_i = 0, buf_unread_i = 0, two_stop_i = 0, par_odd_i = 0;
  logic [DATA_W-1:0] data_i = '0;
  logic [STOP_W-1:0] stop_i = '1;
  logic [1:0] mode_i = 2'b00;
  logic fe_en_i = 0, pe_en_i = 0, oe_en_i = 0;
  logic clr_fe_i = 0, clr_pe_i = 0, clr_oe_i = 0, clr_irq_i = 0;
  logic rx_done_o, fe_o, pe_o, oe_o, err_irq_o;

  int   n_chk = 0, n_fail = 0;
  exp_t q_exp[$];
  exp_t model = '0;
  string q_tag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ser_rx_err_det #(.DATA_W(DATA_W), .STOP_W(STOP_W)) dut (.*);

  task automatic check(input string tag, input exp_t act, input exp_t exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual fe/pe/oe/irq=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic exp_t outs();
    return '{fe: fe_o, pe: pe_o, oe: oe_o, irq: err_irq_o};
  endfunction

  // frame: m = {parity present, async}, en = {oe, pe, fe}, clr = {irq, oe, pe, fe}
  task automatic frame(input string tag, input logic [DATA_W-1:0] d, input logic p,
                       input logic [1:0] st, input logic [1:0] m, input logic two,
                       input logic odd, input logic [2:0] en, input logic unread,
                       input logic [3:0] clr);
    logic nfe, npe, noe;
    exp_t e;
    @(negedge clk_i);
    data_i = d; par_bit_i = p; stop_i = st; mode_i = m; two_stop_i = two;
    par_odd_i = odd; {oe_en_i, pe_en_i, fe_en_i} = en; buf_unread_i = unread;
    {clr_irq_i, clr_oe_i, clr_pe_i, clr_fe_i} = clr;
    frame_done_i = 1'b1;
    nfe = en[0] && m[0] && (!st[0] || (two && !st[1]));
    npe = en[1] && m[0] && m[1] && (((^d) ^ p) != odd);
    noe = en[2] && unread;
    e.fe  = nfe | (model.fe & ~clr[0]);
    e.pe  = npe | (model.pe & ~clr[1]);
    e.oe  = noe | (model.oe & ~clr[2]);
    e.irq = (nfe | npe | noe) | (model.irq & ~clr[3]);
    model = e;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk_i);
    frame_done_i = 1'b0;
    {clr_irq_i, clr_oe_i, clr_pe_i, clr_fe_i} = '0;
  endtask

  task automatic clear_only(input string tag, input logic [3:0] clr);
    @(negedge clk_i);
    {clr_irq_i, clr_oe_i, clr_pe_i, clr_fe_i} = clr;
    model.fe  = model.fe & ~clr[0];
    model.pe  = model.pe & ~clr[1];
    model.oe  = model.oe & ~clr[2];
    model.irq = model.irq & ~clr[3];
    @(negedge clk_i);
    {clr_irq_i, clr_oe_i, clr_pe_i, clr_fe_i} = '0;
    check(tag, outs(), model);
  endtask

  // monitor: one queued expectation per done pulse
  always @(negedge clk_i) begin
    if (rst_ni && rx_done_o) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: actual rx_done_o=1 expected 0 (no frame pending)");
      end else begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, outs(), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset", outs(), '0);
    n_chk++;
    if (rx_done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: actual rx_done_o=%b expected 0", rx_done_o);
    end
    rst_ni = 1'b1;

    frame("R4 clean even",      8'hA5, 1'b0, 2'b11, 2'b11, 1'b1, 1'b0, 3'b111, 1'b0, 4'h0);
    frame("R2 first stop low",  8'h00, 1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 3'b001, 1'b0, 4'hF);
    frame("R3 two stop second", 8'h00, 1'b0, 2'b01, 2'b01, 1'b1, 1'b0, 3'b001, 1'b0, 4'hF);
    frame("R3 one stop ignore", 8'h00, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 3'b001, 1'b0, 4'hF);
    frame("R4 even bad",        8'h01, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 3'b010, 1'b0, 4'hF);
    frame("R4 odd good",        8'h01, 1'b0, 2'b11, 2'b11, 1'b0, 1'b1, 3'b010, 1'b0, 4'hF);
    frame("R4 odd bad",         8'h03, 1'b0, 2'b11, 2'b11, 1'b0, 1'b1, 3'b010, 1'b0, 4'hF);
    frame("R4 no parity mode",  8'h01, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 3'b010, 1'b0, 4'hF);
    frame("R5 sync ignores",    8'h01, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 3'b011, 1'b0, 4'hF);
    frame("R6 sync overrun",    8'h00, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 3'b100, 1'b1, 4'hF);
    frame("R11 all disabled",   8'h01, 1'b0, 2'b00, 2'b11, 1'b1, 1'b0, 3'b000, 1'b1, 4'hF);
    frame("R9 all three",       8'h01, 1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 3'b111, 1'b1, 4'hF);
    frame("R8 sticky no clear", 8'h00, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 3'b111, 1'b0, 4'h0);
    clear_only("R8 clear pe only", 4'b0010);
    clear_only("R8 clear rest",    4'b1101);
    frame("R8 set beats clear", 8'h00, 1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 3'b001, 1'b0, 4'b1001);
    frame("R7 idle frame keeps", 8'h00, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 3'b111, 1'b0, 4'h0);
    clear_only("R8 clear all",     4'hF);
    frame("R7 clean no irq",    8'h0F, 1'b0, 2'b11, 2'b11, 1'b1, 1'b0, 3'b111, 1'b0, 4'h0);

    repeat (3) @(negedge clk_i);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R1: actual %0d pending results expected 0", q_exp.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule